// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block joins two symmetric 8-bit ports, called side A and side B. Each port carries a data byte with a parity bit. Traffic from A to B passes through its own transparent storage stage, and traffic from B to A passes through a second one. Each stage has its own enable. When the enable is high, the stage passes the input straight to the far side in the same cycle. When the enable is low, the stage keeps the value it last took in.

On the way out, a single mode input picks the parity bit that is sent. It is either rebuilt from the stored byte or forwarded unchanged from the incoming parity bit. A sense input picks even or odd parity, and that choice applies to both generation and checking.

Both ports are checked for parity all the time. This does not depend on mode, direction, storage state or output enables. Each side has an active-low error flag and a matching pull-down enable, which together model an open-drain error line. Per-direction active-low output enables become drive-enable outputs. The two drive-enables are never high together.

Top module: `lpt_transceiver`

## Requirements
- R1: With le_ab high, b_dout equals a_din in the same cycle. With le_ba high, a_dout equals b_din in the same cycle.
- R2: With a latch enable low, the outgoing byte and the stored parity bit of that direction keep the values present at the last rising clock edge at which that enable was high. Input changes during that time have no effect on them.
- R3: With feed_sel = 0 (generate), the outgoing parity bit is rebuilt from the outgoing byte. With odd_sel = 0, the ones across the 8 bits plus parity are even in number. With odd_sel = 1, they are odd in number.
- R4: With feed_sel = 1 (feed-through), the outgoing parity bit is the incoming parity bit taken through the same storage stage as the byte.
- R5: The B-to-A direction behaves the same as A-to-B under le_ba, with the same mode and sense inputs.
- R6: Each side's checker looks at that side's raw inputs, ahead of its storage stage. When the ones count of the 8 bits plus the parity bit does not match the sense chosen by odd_sel, the flag err_x_n is low and err_x_drv is high. Otherwise err_x_n is high and err_x_drv is low. This holds in both modes and regardless of latch or output enables.
- R7: b_drv_en equals !oe_ab_n. a_drv_en is high only when oe_ba_n is low and oe_ab_n is high, so the two drive-enables are never high together.
- R8: A synchronous active-low reset clears both stored bytes and stored parity bits to zero. With a latch enable low after reset, that side outputs byte 0x00. Its parity output is 0 in feed-through mode and equals odd_sel in generate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that updates the stored copies |
| rst_n | input | 1 | Synchronous active-low reset |
| a_din | input | 8 | Side A incoming byte |
| a_pin | input | 1 | Side A incoming parity bit |
| b_din | input | 8 | Side B incoming byte |
| b_pin | input | 1 | Side B incoming parity bit |
| le_ab | input | 1 | A-to-B storage enable, high = transparent |
| le_ba | input | 1 | B-to-A storage enable, high = transparent |
| oe_ab_n | input | 1 | Active-low output enable for driving side B |
| oe_ba_n | input | 1 | Active-low output enable for driving side A |
| feed_sel | input | 1 | 0 = generate parity, 1 = feed parity through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| a_dout | output | 8 | Byte sent toward side A |
| a_pout | output | 1 | Parity bit sent toward side A |
| a_drv_en | output | 1 | Drive-enable for side A data and parity |
| b_dout | output | 8 | Byte sent toward side B |
| b_pout | output | 1 | Parity bit sent toward side B |
| b_drv_en | output | 1 | Drive-enable for side B data and parity |
| err_a_n | output | 1 | Side A parity error flag, low on error |
| err_a_drv | output | 1 | Pull-down enable for side A error line |
| err_b_n | output | 1 | Side B parity error flag, low on error |
| err_b_drv | output | 1 | Pull-down enable for side B error line |

## Verification
Holding a direction's stored byte and reporting a parity error on that same side's raw input can happen in the same cycle. The bench captures a good byte, drops the enable, and then presents a different byte with a single-bit parity fault on the same port. In that cycle the outgoing byte and parity must still show the captured values, and the side's error flag must already be reporting the fault on the new input. The bench then clears the fault while the stage still holds and checks that the flag returns to its idle state while the output stays unchanged.

// File: rtl/lpt_pkg.sv
// Package: shared encodings for the latched parity transceiver.
// Assumes: single-bit mode and sense inputs map directly to these enums.
package lpt_pkg;
    typedef enum logic {
        PSENSE_EVEN = 1'b0,
        PSENSE_ODD  = 1'b1
    } par_sense_e;

    typedef enum logic {
        PMODE_GEN  = 1'b0,
        PMODE_FEED = 1'b1
    } par_mode_e;
endpackage

// File: rtl/lpt_store.sv
// Module: transparent storage stage built from a flop and a bypass mux.
// While le is high the input passes straight through and is captured on
// every rising clock edge; while le is low the last captured word is shown.
// Assumes: le is synchronous to clk; reset is synchronous and active low.
module lpt_store #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held_q;

    // Capture the input while the stage is open; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (le) begin
            held_q <= d;
        end
    end

    // Open stage bypasses the flop, closed stage shows the stored word.
    always_comb begin
        q = le ? d : held_q;
    end
endmodule

// File: rtl/lpt_par_gen.sv
// Module: parity bit generator for a data word.
// Result makes the ones count of data plus the result even (sense even)
// or odd (sense odd). Assumes: pure combinational use.
module lpt_par_gen #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] data,
    input  logic         odd,
    output logic         par
);
    import lpt_pkg::*;

    par_sense_e sense;

    // Fold the word and flip the result for odd sense.
    always_comb begin
        sense = par_sense_e'(odd);
        par   = (^data) ^ (sense == PSENSE_ODD);
    end
endmodule

// File: rtl/lpt_par_chk.sv
// Module: parity checker for one port's raw data and parity bit.
// err is high when the ones count of data and parity disagrees with
// the selected sense. Assumes: pure combinational use.
module lpt_par_chk #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] data,
    input  logic         par,
    input  logic         odd,
    output logic         err
);
    import lpt_pkg::*;

    logic ones_odd;

    // Compare the parity of the whole code word with the wanted sense.
    always_comb begin
        ones_odd = ^{data, par};
        err      = (par_sense_e'(odd) == PSENSE_ODD) ? !ones_odd : ones_odd;
    end
endmodule

// File: rtl/lpt_path.sv
// Module: one transfer direction, made of a storage stage for byte and parity
// followed by a choice between the regenerated and the forwarded parity bit.
// Assumes: mode and sense inputs are shared with the opposite direction.
module lpt_path #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         feed,
    input  logic         odd,
    input  logic [W-1:0] din,
    input  logic         pin,
    output logic [W-1:0] dout,
    output logic         pout
);
    import lpt_pkg::*;

    localparam int unsigned SW = W + 1;

    logic [SW-1:0] stored;
    logic          gen_par;

    lpt_store #(.W(SW)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .d     ({din, pin}),
        .q     (stored)
    );

    lpt_par_gen #(.W(W)) gen_i (
        .data (stored[SW-1:1]),
        .odd  (odd),
        .par  (gen_par)
    );

    // Select the outgoing parity bit according to the mode input.
    always_comb begin
        dout = stored[SW-1:1];
        pout = (par_mode_e'(feed) == PMODE_FEED) ? stored[0] : gen_par;
    end
endmodule

// File: rtl/lpt_transceiver.sv
// Module: top of the latched parity transceiver.
// Two mirrored directions, two raw-input checkers with open-drain style
// flags, and drive-enables derived from active-low output enables with
// A-side driving suppressed when both enables are asserted.
// Assumes: all inputs are synchronous to clk.
module lpt_transceiver #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_din,
    input  logic              a_pin,
    input  logic [DATA_W-1:0] b_din,
    input  logic              b_pin,
    input  logic              le_ab,
    input  logic              le_ba,
    input  logic              oe_ab_n,
    input  logic              oe_ba_n,
    input  logic              feed_sel,
    input  logic              odd_sel,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_pout,
    output logic              a_drv_en,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_pout,
    output logic              b_drv_en,
    output logic              err_a_n,
    output logic              err_a_drv,
    output logic              err_b_n,
    output logic              err_b_drv
);
    logic err_a;
    logic err_b;

    lpt_path #(.W(DATA_W)) ab_i (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le_ab),
        .feed  (feed_sel),
        .odd   (odd_sel),
        .din   (a_din),
        .pin   (a_pin),
        .dout  (b_dout),
        .pout  (b_pout)
    );

    lpt_path #(.W(DATA_W)) ba_i (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le_ba),
        .feed  (feed_sel),
        .odd   (odd_sel),
        .din   (b_din),
        .pin   (b_pin),
        .dout  (a_dout),
        .pout  (a_pout)
    );

    lpt_par_chk #(.W(DATA_W)) chk_a_i (
        .data (a_din),
        .par  (a_pin),
        .odd  (odd_sel),
        .err  (err_a)
    );

    lpt_par_chk #(.W(DATA_W)) chk_b_i (
        .data (b_din),
        .par  (b_pin),
        .odd  (odd_sel),
        .err  (err_b)
    );

    // Turn the checker results into low-active flags with pull-down enables.
    always_comb begin
        err_a_n   = !err_a;
        err_a_drv = err_a;
        err_b_n   = !err_b;
        err_b_drv = err_b;
    end

    // Derive drive-enables; A-to-B wins when both directions are requested.
    always_comb begin
        b_drv_en = !oe_ab_n;
        a_drv_en = !oe_ba_n && oe_ab_n;
    end
endmodule

// File: rtl/lpt_transceiver_chk.sv
// Module: property checker for lpt_transceiver, attached through bind.
// Assumes: signals are sampled at the rising clock edge.
module lpt_transceiver_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_din,
    input logic              a_pin,
    input logic [DATA_W-1:0] b_din,
    input logic              b_pin,
    input logic              le_ab,
    input logic              le_ba,
    input logic              feed_sel,
    input logic              odd_sel,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_pout,
    input logic              a_drv_en,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_pout,
    input logic              b_drv_en,
    input logic              err_a_n,
    input logic              err_a_drv,
    input logic              err_b_n,
    input logic              err_b_drv
);
    p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        le_ab |-> (b_dout == a_din));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!le_ab) && !le_ab) |-> $stable(b_dout));

    p_gen_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !feed_sel |-> ((^{b_dout, b_pout}) == odd_sel));

    p_feed_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_sel && le_ab) |-> (b_pout == a_pin));

    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        le_ba |-> ((a_dout == b_din) && (feed_sel ? (a_pout == b_pin)
                                                  : ((^{a_dout, a_pout}) == odd_sel))));

    p_err_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((^{a_din, a_pin}) != odd_sel) == err_a_drv) && (err_a_n != err_a_drv));

    p_err_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((^{b_din, b_pin}) != odd_sel) == err_b_drv) && (err_b_n != err_b_drv));

    p_drive_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_drv_en && b_drv_en));

    p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !le_ab && !le_ba) |-> ((b_dout == '0) && (a_dout == '0)));
endmodule

bind lpt_transceiver lpt_transceiver_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_din     (a_din),
    .a_pin     (a_pin),
    .b_din     (b_din),
    .b_pin     (b_pin),
    .le_ab     (le_ab),
    .le_ba     (le_ba),
    .feed_sel  (feed_sel),
    .odd_sel   (odd_sel),
    .a_dout    (a_dout),
    .a_pout    (a_pout),
    .a_drv_en  (a_drv_en),
    .b_dout    (b_dout),
    .b_pout    (b_pout),
    .b_drv_en  (b_drv_en),
    .err_a_n   (err_a_n),
    .err_a_drv (err_a_drv),
    .err_b_n   (err_b_n),
    .err_b_drv (err_b_drv)
);

// File: tb/lpt_transceiver_tb_top.sv
module lpt_transceiver_tb_top;
    localparam int unsigned NVEC = 10;

    // Vector: {odd_sel, feed_sel, data[7:0], par, exp_out_par, exp_err}
    localparam logic [12:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h03, 1'b1, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b1},
        {1'b1, 1'b0, 8'h80, 1'b1, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_din = '0;
    logic       a_pin = 1'b0;
    logic [7:0] b_din = '0;
    logic       b_pin = 1'b0;
    logic       le_ab = 1'b0;
    logic       le_ba = 1'b0;
    logic       oe_ab_n = 1'b1;
    logic       oe_ba_n = 1'b1;
    logic       feed_sel = 1'b1;
    logic       odd_sel = 1'b0;
    logic [7:0] a_dout;
    logic       a_pout;
    logic       a_drv_en;
    logic [7:0] b_dout;
    logic       b_pout;
    logic       b_drv_en;
    logic       err_a_n;
    logic       err_a_drv;
    logic       err_b_n;
    logic       err_b_drv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpt_transceiver dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_din     (a_din),
        .a_pin     (a_pin),
        .b_din     (b_din),
        .b_pin     (b_pin),
        .le_ab     (le_ab),
        .le_ba     (le_ba),
        .oe_ab_n   (oe_ab_n),
        .oe_ba_n   (oe_ba_n),
        .feed_sel  (feed_sel),
        .odd_sel   (odd_sel),
        .a_dout    (a_dout),
        .a_pout    (a_pout),
        .a_drv_en  (a_drv_en),
        .b_dout    (b_dout),
        .b_pout    (b_pout),
        .b_drv_en  (b_drv_en),
        .err_a_n   (err_a_n),
        .err_a_drv (err_a_drv),
        .err_b_n   (err_b_n),
        .err_b_drv (err_b_drv)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Move to the falling edge, then let combinational outputs settle.
    task automatic to_drive();
        @(negedge clk);
    endtask

    task automatic settle();
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R8: reset clears stored words; stages closed afterwards.
        repeat (3) @(posedge clk);
        to_drive();
        rst_n = 1'b1;
        a_din = 8'hE7; b_din = 8'h9C; a_pin = 1'b1; b_pin = 1'b1;
        settle();
        chk("R8", "b_dout after reset", b_dout, 8'h00);
        chk("R8", "a_dout after reset", a_dout, 8'h00);
        chk("R8", "b_pout feed after reset", b_pout, 1'b0);
        to_drive();
        feed_sel = 1'b0; odd_sel = 1'b1;
        settle();
        chk("R8", "b_pout gen odd after reset", b_pout, 1'b1);
        chk("R8", "a_pout gen odd after reset", a_pout, 1'b1);

        // R1 R3 R4 R5 R6: table walk, both directions open.
        oe_ab_n = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            to_drive();
            le_ab = 1'b1; le_ba = 1'b1;
            odd_sel  = VECS[i][12];
            feed_sel = VECS[i][11];
            a_din = VECS[i][10:3]; a_pin = VECS[i][2];
            b_din = VECS[i][10:3]; b_pin = VECS[i][2];
            settle();
            chk("R1", "b_dout transparent", b_dout, VECS[i][10:3]);
            chk(feed_sel ? "R4" : "R3", "b_pout", b_pout, VECS[i][1]);
            chk("R5", "a_dout transparent", a_dout, VECS[i][10:3]);
            chk("R5", "a_pout", a_pout, VECS[i][1]);
            chk("R6", "err_a_drv", err_a_drv, VECS[i][0]);
            chk("R6", "err_a_n", err_a_n, !VECS[i][0]);
            chk("R6", "err_b_drv", err_b_drv, VECS[i][0]);
            chk("R6", "err_b_n", err_b_n, !VECS[i][0]);
        end

        // R2: capture 0x5A/0 (A) and 0x81/1 (B), then close and change inputs.
        to_drive();
        feed_sel = 1'b1; odd_sel = 1'b0;
        a_din = 8'h5A; a_pin = 1'b0; b_din = 8'h81; b_pin = 1'b1;
        @(posedge clk);
        to_drive();
        le_ab = 1'b0; le_ba = 1'b0;
        // Same cycle: hold plus single-bit error on A raw input (C3 has 4 ones).
        a_din = 8'hC3; a_pin = 1'b1;
        b_din = 8'h80; b_pin = 1'b1;
        settle();
        chk("R2", "b_dout held", b_dout, 8'h5A);
        chk("R2", "b_pout held feed", b_pout, 1'b0);
        chk("R2", "a_dout held", a_dout, 8'h81);
        chk("R2", "a_pout held feed", a_pout, 1'b1);
        chk("R6", "err_a_drv while holding", err_a_drv, 1'b1);
        chk("R6", "err_b_drv while holding", err_b_drv, 1'b0);
        @(posedge clk);
        to_drive();
        a_pin = 1'b0; b_pin = 1'b0;
        settle();
        chk("R2", "b_dout still held", b_dout, 8'h5A);
        chk("R6", "err_a_n cleared", err_a_n, 1'b1);
        chk("R6", "err_b_n raised on B", err_b_n, 1'b0);
        // R3 on held word: generate mode, 0x5A has 4 ones.
        feed_sel = 1'b0;
        settle();
        chk("R3", "b_pout gen even held", b_pout, 1'b0);
        chk("R3", "a_pout gen even held (0x81)", a_pout, 1'b0);
        odd_sel = 1'b1;
        settle();
        chk("R3", "b_pout gen odd held", b_pout, 1'b1);
        chk("R6", "err_b odd sense", err_b_drv, 1'b0);

        // R7: output enable combinations.
        to_drive();
        oe_ab_n = 1'b0; oe_ba_n = 1'b1; settle();
        chk("R7", "ab only b_drv_en", b_drv_en, 1'b1);
        chk("R7", "ab only a_drv_en", a_drv_en, 1'b0);
        oe_ab_n = 1'b1; oe_ba_n = 1'b0; settle();
        chk("R7", "ba only b_drv_en", b_drv_en, 1'b0);
        chk("R7", "ba only a_drv_en", a_drv_en, 1'b1);
        oe_ab_n = 1'b0; oe_ba_n = 1'b0; settle();
        chk("R7", "both b_drv_en", b_drv_en, 1'b1);
        chk("R7", "both a_drv_en", a_drv_en, 1'b0);
        oe_ab_n = 1'b1; oe_ba_n = 1'b1; settle();
        chk("R7", "none b_drv_en", b_drv_en, 1'b0);
        chk("R7", "none a_drv_en", a_drv_en, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule